// File: doc/BRIEF.md
# Ladder Rung Bit-Instruction Evaluator

This block runs ladder-logic bit instructions one per clock against a 32-bit bit memory. The caller steps through a program in scan order (left to right, then rung by rung, top to bottom) and presents an opcode, a bit address, a history-slot index and the rung state coming in from the left. The block returns the rung state that leaves the instruction on the same cycle. Any memory write takes effect at the next clock edge. Series contacts form an AND because the caller chains the returned rung state into the next instruction. Parallel branches form an OR, and the caller combines those outside the block.

Contacts test a memory bit or detect an edge of the rung state. Coils write a memory bit. Every transition instruction keeps its previous rung state in one of 16 history slots. A slot is updated at most once per scan, and the scan-start strobe marks the first instruction of a new scan. A power-cycle pulse clears every memory bit that was last written by a non-retentive instruction and keeps the bits that were last written by a retentive coil. It also clears all history.

Top module: `ladder_rung_eval`

## Requirements
- R1: A normally-open contact (opcode 1) returns rung_in AND bit_mem[addr]. A normally-closed contact (opcode 2) returns rung_in AND NOT bit_mem[addr]. Neither writes memory.
- R2: A plain coil (opcode 5) writes rung_in to bit_mem[addr]. A negated coil (opcode 6) writes NOT rung_in. Both return rung_in.
- R3: A set coil (opcode 7) writes 1 and a reset coil (opcode 8) writes 0, each only when rung_in is 1. When rung_in is 0 the bit keeps its value. Both return rung_in.
- R4: A rising transition contact (opcode 3) returns 1 only when rung_in is 1 and its history slot holds 0.
- R5: A falling transition contact (opcode 4) returns 1 only when rung_in is 0 and its history slot holds 1.
- R6: Transition instructions (opcodes 3, 4, 12, 13) store rung_in into history slot `slot` at most once per scan. A scan begins on a cycle with scan_start high, and that cycle's instruction counts as part of the new scan. A later instruction that uses the same slot in the same scan leaves the slot unchanged.
- R7: A rising transition-sensing coil (opcode 12) writes 1 when rung_in is 1 and its slot holds 0, and otherwise leaves the bit unchanged. A falling transition-sensing coil (opcode 13) writes 0 when rung_in is 0 and its slot holds 1, and otherwise leaves the bit unchanged. Both return rung_in.
- R8: The retentive coil (opcode 9), retentive set (opcode 10) and retentive reset (opcode 11) behave as opcodes 5, 7 and 8. A bit they last wrote keeps its value through a power-cycle pulse, while every other bit becomes 0.
- R9: Retention is decided by the kind of instruction that last wrote the bit. A bit written by a retentive coil and then written again by a non-retentive coil is cleared by the next power cycle.
- R10: On a cycle with pwr_cycle high, the presented instruction writes neither memory nor history, and all history slots become 0.
- R11: Opcodes 0, 14 and 15 are no-ops: they return rung_in and change no memory bit.
- R12: A synchronous active-high rst clears all memory bits, retention flags and history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Instruction opcode |
| addr | input | 5 | Bit memory address |
| slot | input | 4 | History slot index of a transition instruction |
| rung_in | input | 1 | Rung state from the left |
| scan_start | input | 1 | High with the first instruction of a scan |
| pwr_cycle | input | 1 | Power-cycle pulse |
| rung_out | output | 1 | Rung state to the right (combinational) |
| bit_mem | output | 32 | Current bit memory contents |

## Verification
The bench builds the block with its default parameters: 32 memory bits and 16 history slots. At these sizes, a handful of addresses and slots is enough to show that writes and history stay separate per address and per slot. The sizes also let a single 32-bit compare after a power cycle confirm, in one step, which bits were retained and which were cleared. A slot that is reused inside one scan, followed by a check in the next scan, shows that history is updated only once per scan.

// File: rtl/lre_pkg.sv
package lre_pkg;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_NO    = 4'd1,
        OP_NC    = 4'd2,
        OP_PTC   = 4'd3,
        OP_FTC   = 4'd4,
        OP_OUT   = 4'd5,
        OP_NOUT  = 4'd6,
        OP_SET   = 4'd7,
        OP_CLR   = 4'd8,
        OP_ROUT  = 4'd9,
        OP_RSET  = 4'd10,
        OP_RCLR  = 4'd11,
        OP_PCOIL = 4'd12,
        OP_FCOIL = 4'd13
    } op_e;

    typedef enum logic [2:0] {
        RK_PASS, RK_NO, RK_NC, RK_RISE, RK_FALL
    } rung_kind_e;

    typedef enum logic [2:0] {
        WK_NONE, WK_RUNG, WK_NRUNG, WK_SET, WK_CLR, WK_RISE, WK_FALL
    } write_kind_e;

    typedef struct packed {
        rung_kind_e  rk;
        write_kind_e wk;
        logic        retentive;
        logic        hist_use;
    } ctrl_t;

    typedef struct packed {
        logic we;
        logic wd;
    } wreq_t;

    function automatic wreq_t coil_write(write_kind_e wk, logic rin, logic prev);
        wreq_t r;
        r = '{we: 1'b0, wd: 1'b0};
        case (wk)
            WK_RUNG:  r = '{we: 1'b1, wd: rin};
            WK_NRUNG: r = '{we: 1'b1, wd: ~rin};
            WK_SET:   r = '{we: rin, wd: 1'b1};
            WK_CLR:   r = '{we: rin, wd: 1'b0};
            WK_RISE:  r = '{we: rin & ~prev, wd: 1'b1};
            WK_FALL:  r = '{we: ~rin & prev, wd: 1'b0};
            default:  r = '{we: 1'b0, wd: 1'b0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lre_decode.sv
module lre_decode
    import lre_pkg::*;
(
    input  logic [3:0] op,
    output ctrl_t      ctl
);
    always_comb begin
        ctl = '{rk: RK_PASS, wk: WK_NONE, retentive: 1'b0, hist_use: 1'b0};
        case (op)
            OP_NO:    ctl.rk = RK_NO;
            OP_NC:    ctl.rk = RK_NC;
            OP_PTC:   begin ctl.rk = RK_RISE; ctl.hist_use = 1'b1; end
            OP_FTC:   begin ctl.rk = RK_FALL; ctl.hist_use = 1'b1; end
            OP_OUT:   ctl.wk = WK_RUNG;
            OP_NOUT:  ctl.wk = WK_NRUNG;
            OP_SET:   ctl.wk = WK_SET;
            OP_CLR:   ctl.wk = WK_CLR;
            OP_ROUT:  begin ctl.wk = WK_RUNG; ctl.retentive = 1'b1; end
            OP_RSET:  begin ctl.wk = WK_SET;  ctl.retentive = 1'b1; end
            OP_RCLR:  begin ctl.wk = WK_CLR;  ctl.retentive = 1'b1; end
            OP_PCOIL: begin ctl.wk = WK_RISE; ctl.hist_use = 1'b1; end
            OP_FCOIL: begin ctl.wk = WK_FALL; ctl.hist_use = 1'b1; end
            default:  ;
        endcase
    end
endmodule

// File: rtl/lre_history.sv
module lre_history #(
    parameter int SLOTS = 16,
    localparam int SW = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pwr_cycle,
    input  logic          scan_start,
    input  logic          upd,
    input  logic [SW-1:0] slot,
    input  logic          rin,
    output logic [SLOTS-1:0] hist
);
    logic [SLOTS-1:0] touched;
    logic             may_write;

    assign may_write = upd && (scan_start || !touched[slot]);

    always_ff @(posedge clk) begin
        if (rst || pwr_cycle) begin
            hist    <= '0;
            touched <= '0;
        end else begin
            if (scan_start)
                touched <= '0;
            if (may_write) begin
                hist[slot]    <= rin;
                touched[slot] <= 1'b1;
            end
        end
    end

    // R6: a slot already used in this scan is left alone
    a_r6_once_per_scan: assert property (@(posedge clk) disable iff (rst)
        (upd && !scan_start && !pwr_cycle && touched[slot]) |=> $stable(hist));

    // R10: power cycle empties history
    a_r10_hist_clear: assert property (@(posedge clk) disable iff (rst)
        pwr_cycle |=> (hist == '0));
endmodule

// File: rtl/lre_bitmem.sv
module lre_bitmem #(
    parameter int BITS = 32,
    localparam int AW = $clog2(BITS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pwr_cycle,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic          wd,
    input  logic          ret_kind,
    output logic [BITS-1:0] mem
);
    logic [BITS-1:0] ret_flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem      <= '0;
            ret_flag <= '0;
        end else if (pwr_cycle) begin
            mem <= mem & ret_flag;
        end else if (we) begin
            mem[addr]      <= wd;
            ret_flag[addr] <= ret_kind;
        end
    end

    // R8: unflagged bits are cleared by a power cycle
    a_r8_clear_volatile: assert property (@(posedge clk) disable iff (rst)
        pwr_cycle |=> ((mem & ~$past(ret_flag)) == '0));

    // R8: flagged bits survive a power cycle
    a_r8_keep_retained: assert property (@(posedge clk) disable iff (rst)
        pwr_cycle |=> ((mem & $past(ret_flag)) == ($past(mem) & $past(ret_flag))));
endmodule

// File: rtl/ladder_rung_eval.sv
module ladder_rung_eval
    import lre_pkg::*;
#(
    parameter int MEM_BITS   = 32,
    parameter int HIST_SLOTS = 16,
    localparam int AW = $clog2(MEM_BITS),
    localparam int SW = $clog2(HIST_SLOTS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [3:0]          op,
    input  logic [AW-1:0]       addr,
    input  logic [SW-1:0]       slot,
    input  logic                rung_in,
    input  logic                scan_start,
    input  logic                pwr_cycle,
    output logic                rung_out,
    output logic [MEM_BITS-1:0] bit_mem
);
    ctrl_t                 ctl;
    wreq_t                 wreq;
    logic [HIST_SLOTS-1:0] hist;
    logic                  bit_rd;
    logic                  prev_rd;

    lre_decode u_dec (.op(op), .ctl(ctl));

    lre_history #(.SLOTS(HIST_SLOTS)) u_hist (
        .clk(clk), .rst(rst), .pwr_cycle(pwr_cycle), .scan_start(scan_start),
        .upd(ctl.hist_use), .slot(slot), .rin(rung_in), .hist(hist)
    );

    assign bit_rd  = bit_mem[addr];
    assign prev_rd = hist[slot];

    always_comb begin
        case (ctl.rk)
            RK_NO:   rung_out = rung_in & bit_rd;
            RK_NC:   rung_out = rung_in & ~bit_rd;
            RK_RISE: rung_out = rung_in & ~prev_rd;
            RK_FALL: rung_out = ~rung_in & prev_rd;
            default: rung_out = rung_in;
        endcase
        wreq = coil_write(ctl.wk, rung_in, prev_rd);
    end

    lre_bitmem #(.BITS(MEM_BITS)) u_mem (
        .clk(clk), .rst(rst), .pwr_cycle(pwr_cycle), .we(wreq.we),
        .addr(addr), .wd(wreq.wd), .ret_kind(ctl.retentive), .mem(bit_mem)
    );

    // R3: set coil with a true rung leaves the bit at 1
    a_r3_set_takes: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SET && rung_in && !pwr_cycle) |=> bit_mem[$past(addr)]);

    // R3: reset coil with a false rung leaves memory untouched
    a_r3_clr_holds: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CLR && !rung_in && !pwr_cycle) |=> $stable(bit_mem));

    // R11: no-op opcodes leave memory alone
    a_r11_noop_mem: assert property (@(posedge clk) disable iff (rst)
        ((op == 4'd0 || op >= 4'd14) && !pwr_cycle) |=> $stable(bit_mem));
endmodule

// File: tb/sim_ladder_rung_eval.sv
`timescale 1ns/100ps
module sim_ladder_rung_eval;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  op;
    logic [4:0]  addr;
    logic [3:0]  slot;
    logic        rung_in, scan_start, pwr_cycle;
    logic        rung_out;
    logic [31:0] bit_mem;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ladder_rung_eval u0 (
        .clk(clk), .rst(rst), .op(op), .addr(addr), .slot(slot),
        .rung_in(rung_in), .scan_start(scan_start), .pwr_cycle(pwr_cycle),
        .rung_out(rung_out), .bit_mem(bit_mem)
    );

    // {req[3:0], op[3:0], addr[4:0], slot[3:0], rin, scan, exp_out, exp_bit}
    localparam int NV = 35;
    localparam logic [20:0] VEC [NV] = '{
        {4'd3, 4'd7,  5'd3,  4'd0, 1'b1, 1'b1, 1'b1, 1'b1},  // R3 set
        {4'd1, 4'd1,  5'd3,  4'd0, 1'b1, 1'b0, 1'b1, 1'b1},  // R1 NO on 1
        {4'd1, 4'd2,  5'd3,  4'd0, 1'b1, 1'b0, 1'b0, 1'b1},  // R1 NC on 1
        {4'd1, 4'd1,  5'd3,  4'd0, 1'b0, 1'b0, 1'b0, 1'b1},  // R1 NO, rung false
        {4'd3, 4'd8,  5'd3,  4'd0, 1'b0, 1'b0, 1'b0, 1'b1},  // R3 reset ignored
        {4'd3, 4'd8,  5'd3,  4'd0, 1'b1, 1'b0, 1'b1, 1'b0},  // R3 reset takes
        {4'd1, 4'd2,  5'd3,  4'd0, 1'b1, 1'b0, 1'b1, 1'b0},  // R1 NC on 0
        {4'd2, 4'd5,  5'd5,  4'd0, 1'b1, 1'b0, 1'b1, 1'b1},  // R2 coil 1
        {4'd2, 4'd5,  5'd5,  4'd0, 1'b0, 1'b0, 1'b0, 1'b0},  // R2 coil 0
        {4'd2, 4'd6,  5'd6,  4'd0, 1'b0, 1'b0, 1'b0, 1'b1},  // R2 negated coil
        {4'd2, 4'd6,  5'd6,  4'd0, 1'b1, 1'b0, 1'b1, 1'b0},  // R2 negated coil
        {4'd3, 4'd7,  5'd7,  4'd0, 1'b0, 1'b0, 1'b0, 1'b0},  // R3 set ignored
        {4'd4, 4'd3,  5'd0,  4'd2, 1'b1, 1'b1, 1'b1, 1'b0},  // R4 first rise
        {4'd4, 4'd3,  5'd0,  4'd2, 1'b1, 1'b1, 1'b0, 1'b0},  // R4 held high
        {4'd4, 4'd3,  5'd0,  4'd2, 1'b0, 1'b1, 1'b0, 1'b0},  // R4 low
        {4'd4, 4'd3,  5'd0,  4'd2, 1'b1, 1'b1, 1'b1, 1'b0},  // R4 rise again
        {4'd6, 4'd3,  5'd0,  4'd2, 1'b0, 1'b0, 1'b0, 1'b0},  // R6 same scan reuse
        {4'd6, 4'd3,  5'd0,  4'd2, 1'b1, 1'b1, 1'b0, 1'b0},  // R6 history kept 1
        {4'd5, 4'd4,  5'd0,  4'd4, 1'b1, 1'b1, 1'b0, 1'b0},  // R5 high
        {4'd5, 4'd4,  5'd0,  4'd4, 1'b0, 1'b1, 1'b1, 1'b0},  // R5 first fall
        {4'd5, 4'd4,  5'd0,  4'd4, 1'b0, 1'b1, 1'b0, 1'b0},  // R5 held low
        {4'd7, 4'd12, 5'd9,  4'd5, 1'b0, 1'b1, 1'b0, 1'b0},  // R7 rise coil low
        {4'd7, 4'd12, 5'd9,  4'd5, 1'b1, 1'b1, 1'b1, 1'b1},  // R7 rise coil sets
        {4'd7, 4'd12, 5'd9,  4'd5, 1'b0, 1'b1, 1'b0, 1'b1},  // R7 stays
        {4'd7, 4'd13, 5'd9,  4'd6, 1'b1, 1'b1, 1'b1, 1'b1},  // R7 fall coil high
        {4'd7, 4'd13, 5'd9,  4'd6, 1'b0, 1'b1, 1'b0, 1'b0},  // R7 fall coil clears
        {4'd8, 4'd9,  5'd10, 4'd0, 1'b1, 1'b0, 1'b1, 1'b1},  // R8 retentive coil
        {4'd8, 4'd10, 5'd11, 4'd0, 1'b1, 1'b0, 1'b1, 1'b1},  // R8 retentive set
        {4'd8, 4'd11, 5'd12, 4'd0, 1'b1, 1'b0, 1'b1, 1'b0},  // R8 retentive reset
        {4'd8, 4'd7,  5'd13, 4'd0, 1'b1, 1'b0, 1'b1, 1'b1},  // R8 volatile set
        {4'd9, 4'd9,  5'd14, 4'd0, 1'b1, 1'b0, 1'b1, 1'b1},  // R9 retentive first
        {4'd9, 4'd5,  5'd14, 4'd0, 1'b1, 1'b0, 1'b1, 1'b1},  // R9 then plain coil
        {4'd11, 4'd0,  5'd14, 4'd0, 1'b0, 1'b0, 1'b0, 1'b1}, // R11 opcode 0
        {4'd11, 4'd15, 5'd14, 4'd0, 1'b0, 1'b0, 1'b0, 1'b1}, // R11 opcode 15
        {4'd11, 4'd14, 5'd14, 4'd0, 1'b1, 1'b0, 1'b1, 1'b1}  // R11 opcode 14
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    task automatic drive(input logic [3:0] o, input logic [4:0] a, input logic [3:0] s,
                         input logic r, input logic sc, input logic p);
        op = o; addr = a; slot = s; rung_in = r; scan_start = sc; pwr_cycle = p;
    endtask

    initial begin
        #(200000 * 5);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        drive(4'd0, 5'd0, 4'd0, 1'b0, 1'b0, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R12 reset state", bit_mem, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i][16:13], VEC[i][12:8], VEC[i][7:4], VEC[i][3], VEC[i][2], 1'b0);
            #1;
            check($sformatf("R%0d row %0d rung_out", VEC[i][20:17], i), {31'd0, rung_out}, {31'd0, VEC[i][1]});
            @(posedge clk);
            #1;
            check($sformatf("R%0d row %0d bit", VEC[i][20:17], i), {31'd0, bit_mem[VEC[i][12:8]]}, {31'd0, VEC[i][0]});
        end

        // R8 R9 R10: power cycle with a set coil presented at bit 20
        @(negedge clk);
        drive(4'd7, 5'd20, 4'd0, 1'b1, 1'b0, 1'b1);
        @(posedge clk);
        #1;
        check("R8 R9 R10 memory after power cycle", bit_mem, 32'h0000_0C00);

        // R10: history cleared, so a held rising contact fires again
        @(negedge clk);
        drive(4'd3, 5'd0, 4'd2, 1'b1, 1'b1, 1'b0);
        #1;
        check("R10 history cleared", {31'd0, rung_out}, 32'd1);
        @(posedge clk);

        // R12: reset clears retained bits too
        @(negedge clk);
        drive(4'd0, 5'd0, 4'd0, 1'b0, 1'b0, 1'b0);
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        check("R12 reset clears retained", bit_mem, 32'h0);

        finish_run();
    end
endmodule